// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

A real-time clock and calendar that keeps century, year, month, date, day of week, hours, minutes and seconds as packed BCD bytes in 24-hour form. It advances once per second. A free-running divider counts a 32.768 kHz clock-enable input and produces the seconds tick. Month lengths and leap years are corrected in hardware, and the century byte takes part in that correction.

The block holds two copies of the time. The live copy counts whenever the oscillator is enabled. The host copy is what the byte-wide register port returns. A transfer-enable control bit links the two. While the bit is set, the host copy mirrors the live copy, and host writes land in both copies. Clearing the bit freezes the host copy at that instant, so the host can read a coherent snapshot or stage new values. Setting the bit again pushes only the staged bytes into the live copy. Fields the host did not touch keep the values the live copy has counted to.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the time reads century 0x20, year 0x00, month 0x01, date 0x01, weekday 0x01, 00:00:00, and the control byte at 0x0F reads 0x80 (bit 7 transfer enable = 1, bit 6 oscillator off = 0, other bits 0).
- R2: Addresses 0x00..0x07 hold seconds, minutes, hours, weekday, date, month, year and century. A read occurs only when cs_ni=0, we_ni=1 and oe_ni=0, and rdata_o is 0x00 at all other times. A write occurs on each clock edge where cs_ni=0 and we_ni=0.
- R3: While oscillator off = 0, every TICK_DIV cycles with tick_en_i=1 advance the seconds by exactly one.
- R4: While oscillator off = 1, the time holds through any number of enable cycles, and counting resumes after the bit is cleared.
- R5: A single tick at 23:59:59 on weekday 7, date 31, month 12, year 99 carries through every field: the time becomes 00:00:00, weekday 1, date 01, month 01, year 00, and the century increments by one.
- R6: The last day of months 04, 06, 09 and 11 is 30. The last day of months 01, 03, 05, 07, 08, 10 and 12 is 31.
- R7: February ends on day 29 when the year is divisible by 4 and not 00, or when the year is 00 and the century is divisible by 4. Otherwise February ends on day 28.
- R8: Writing 0x0F with bit 7 = 0 freezes the host copy at the value current on that edge. While the bit stays 0, the host copy does not change, and the live copy keeps counting.
- R9: While transfer enable = 0, writes to 0x00..0x07 change only the host copy. When bit 7 is then written to 1, each written field is copied into the live copy, and every unwritten field keeps its counted value.
- R10: While transfer enable = 1, a write to 0x00..0x07 takes effect in the live copy at once and is read back immediately.
- R11: Writes to 0x08..0x0E and 0x10..0x1F change nothing, and reads of those addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | 32.768 kHz clock enable, one cycle wide |
| cs_ni | input | 1 | Register port select, active low |
| oe_ni | input | 1 | Read output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W (5) | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0x00 when no read is active |

## Verification
The bench builds the block with TICK_DIV = 4, so one second costs four enable cycles. This puts the year, century and leap-day rollovers within a few dozen clock edges once the time is preloaded. With that small divider the bench can also count enable cycles on either side of a tick and show that the divider advances exactly on the fourth one. It can show that a frozen snapshot survives several live seconds, and that on release only the staged field overrides the live copy.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int unsigned NUM_FIELDS = 8;
  localparam int unsigned F_SEC  = 0;
  localparam int unsigned F_MIN  = 1;
  localparam int unsigned F_HR   = 2;
  localparam int unsigned F_DOW  = 3;
  localparam int unsigned F_DATE = 4;
  localparam int unsigned F_MON  = 5;
  localparam int unsigned F_YR   = 6;
  localparam int unsigned F_CEN  = 7;

  typedef logic [7:0] bcd_t;
  typedef bcd_t [NUM_FIELDS-1:0] cal_t;

  localparam cal_t CAL_RESET = {8'h20, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  function automatic bcd_t bcd_inc(bcd_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // divisible by 4: even tens with ones 0/4/8, odd tens with ones 2/6
  function automatic logic bcd_div4(bcd_t v);
    if (!v[4]) return (v[3:0] == 4'd0) || (v[3:0] == 4'd4) || (v[3:0] == 4'd8);
    return (v[3:0] == 4'd2) || (v[3:0] == 4'd6);
  endfunction

  function automatic bcd_t month_last(bcd_t mon, logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          step;

  assign step   = en_i && run_i;
  assign tick_o = step && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (step)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_time_adv.sv
module rtc_time_adv
  import rtc_cal_pkg::*;
(
  input  cal_t cur_i,
  output cal_t nxt_o
);
  logic leap;
  logic c_sec, c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    leap = (cur_i[F_YR] == 8'h00) ? bcd_div4(cur_i[F_CEN]) : bcd_div4(cur_i[F_YR]);
    c_sec = cur_i[F_SEC] == 8'h59;
    c_min = c_sec && (cur_i[F_MIN] == 8'h59);
    c_hr  = c_min && (cur_i[F_HR] == 8'h23);
    c_day = c_hr && (cur_i[F_DATE] == month_last(cur_i[F_MON], leap));
    c_mon = c_day && (cur_i[F_MON] == 8'h12);
    c_yr  = c_mon && (cur_i[F_YR] == 8'h99);

    nxt_o = cur_i;
    nxt_o[F_SEC] = c_sec ? 8'h00 : bcd_inc(cur_i[F_SEC]);
    if (c_sec) nxt_o[F_MIN] = c_min ? 8'h00 : bcd_inc(cur_i[F_MIN]);
    if (c_min) nxt_o[F_HR]  = c_hr  ? 8'h00 : bcd_inc(cur_i[F_HR]);
    if (c_hr) begin
      nxt_o[F_DOW]  = (cur_i[F_DOW] == 8'h07) ? 8'h01 : bcd_inc(cur_i[F_DOW]);
      nxt_o[F_DATE] = c_day ? 8'h01 : bcd_inc(cur_i[F_DATE]);
    end
    if (c_day) nxt_o[F_MON] = c_mon ? 8'h01 : bcd_inc(cur_i[F_MON]);
    if (c_mon) nxt_o[F_YR]  = c_yr  ? 8'h00 : bcd_inc(cur_i[F_YR]);
    if (c_yr)  nxt_o[F_CEN] = (cur_i[F_CEN] == 8'h99) ? 8'h00 : bcd_inc(cur_i[F_CEN]);
  end
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import rtc_cal_pkg::*;
#(
  parameter int unsigned TICK_DIV = 32768,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic              cs_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int unsigned FW = $clog2(NUM_FIELDS);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(15);
  localparam int unsigned TE_BIT  = 7;
  localparam int unsigned OSC_BIT = 6;

  cal_t live_q, live_d, ext_q, ext_d, adv;
  logic [NUM_FIELDS-1:0] dirty_q, dirty_d;
  logic te_q, te_d, osc_off_q, osc_off_d;
  logic host_wr, host_rd, field_hit, ctrl_hit, commit, sec_tick;
  logic [FW-1:0] field_idx;

  assign host_wr   = !cs_ni && !we_ni;
  assign host_rd   = !cs_ni && we_ni && !oe_ni;
  assign field_hit = addr_i < ADDR_W'(NUM_FIELDS);
  assign ctrl_hit  = addr_i == CTRL_ADDR;
  assign field_idx = addr_i[FW-1:0];
  assign commit    = host_wr && ctrl_hit && wdata_i[TE_BIT] && !te_q;

  rtc_tick_div #(.DIV(TICK_DIV)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (tick_en_i),
    .run_i (!osc_off_q),
    .tick_o(sec_tick)
  );

  rtc_time_adv u_adv (
    .cur_i(live_q),
    .nxt_o(adv)
  );

  always_comb begin
    live_d    = live_q;
    ext_d     = ext_q;
    dirty_d   = dirty_q;
    te_d      = te_q;
    osc_off_d = osc_off_q;

    // release: staged bytes override live fields, host wins over a coincident tick
    if (commit) begin
      for (int i = 0; i < NUM_FIELDS; i++)
        if (dirty_q[i]) live_d[i] = ext_q[i];
      dirty_d = '0;
    end else if (sec_tick) begin
      live_d = adv;
    end

    if (host_wr && field_hit && te_q) live_d[field_idx] = wdata_i;

    if (host_wr && ctrl_hit) begin
      te_d      = wdata_i[TE_BIT];
      osc_off_d = wdata_i[OSC_BIT];
    end

    if (te_q) begin
      ext_d = live_d;
    end else if (host_wr && field_hit) begin
      ext_d[field_idx]   = wdata_i;
      dirty_d[field_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q    <= CAL_RESET;
      ext_q     <= CAL_RESET;
      dirty_q   <= '0;
      te_q      <= 1'b1;
      osc_off_q <= 1'b0;
    end else begin
      live_q    <= live_d;
      ext_q     <= ext_d;
      dirty_q   <= dirty_d;
      te_q      <= te_d;
      osc_off_q <= osc_off_d;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (host_rd) begin
      if (field_hit)     rdata_o = ext_q[field_idx];
      else if (ctrl_hit) rdata_o = {te_q, osc_off_q, 6'b0};
    end
  end
endmodule

module bcd_calendar_clock_chk
  import rtc_cal_pkg::*;
#(
  parameter int unsigned TICK_DIV = 32768
) (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_i,
  input logic te_i,
  input logic osc_off_i,
  input logic sec_tick_i,
  input cal_t live_i,
  input cal_t ext_i
);
  assert_osc_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_off_i |-> !sec_tick_i);

  assert_tick_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (TICK_DIV > 1) && sec_tick_i |=> !sec_tick_i);

  assert_tick_moves_sec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_i && !wr_i |=> live_i[F_SEC] != $past(live_i[F_SEC]));

  assert_frozen_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !te_i && !wr_i |=> $stable(ext_i));

  assert_mirror_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    te_i && !wr_i |=> ext_i == live_i);
endmodule

bind bcd_calendar_clock bcd_calendar_clock_chk #(.TICK_DIV(TICK_DIV)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (host_wr),
  .te_i      (te_q),
  .osc_off_i (osc_off_q),
  .sec_tick_i(sec_tick),
  .live_i    (live_q),
  .ext_i     (ext_q)
);

// File: tb/bcd_calendar_clock_tb_top.sv
module bcd_calendar_clock_tb_top;
  localparam int unsigned DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
  logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2ns clk = ~clk;

  bcd_calendar_clock #(.TICK_DIV(DIV), .ADDR_W(5)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en),
    .cs_ni(cs_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); cs_n = 0; we_n = 0; addr = a; wdata = d;
    @(negedge clk); cs_n = 1; we_n = 1;
  endtask

  task automatic chk(input string req, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] got;
    @(negedge clk); cs_n = 0; oe_n = 0; we_n = 1; addr = a;
    #1ns got = rdata;
    cs_n = 1; oe_n = 1;
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s addr %h: got %h expected %h", req, a, got, exp);
    end
  endtask

  task automatic pulse(input int n);
    @(negedge clk); tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  // preload through direct writes (transfer enable set)
  task automatic set_all(input logic [7:0] cen, yr, mon, date, dow, hr, mi, se);
    wr(7, cen); wr(6, yr); wr(5, mon); wr(4, date);
    wr(3, dow); wr(2, hr); wr(1, mi); wr(0, se);
  endtask

  task automatic t_reset();
    chk("R1", 0, 8'h00); chk("R1", 1, 8'h00); chk("R1", 2, 8'h00);
    chk("R1", 3, 8'h01); chk("R1", 4, 8'h01); chk("R1", 5, 8'h01);
    chk("R1", 6, 8'h00); chk("R1", 7, 8'h20); chk("R1", 15, 8'h80);
  endtask

  task automatic t_read_gate();
    logic [7:0] got;
    @(negedge clk); cs_n = 0; oe_n = 1; we_n = 1; addr = 7;
    #1ns got = rdata; cs_n = 1;
    n_run++;
    if (got !== 8'h00) begin n_fail++; $display("FAIL R2 oe high: got %h expected 00", got); end
    @(negedge clk); cs_n = 1; oe_n = 0; we_n = 1; addr = 7;
    #1ns got = rdata; oe_n = 1;
    n_run++;
    if (got !== 8'h00) begin n_fail++; $display("FAIL R2 cs high: got %h expected 00", got); end
  endtask

  task automatic t_tick_rate();
    pulse(DIV - 1); chk("R3", 0, 8'h00);
    pulse(1);       chk("R3", 0, 8'h01);
    pulse(DIV * 2); chk("R3", 0, 8'h03);
  endtask

  task automatic t_osc();
    wr(15, 8'hC0); chk("R4", 15, 8'hC0);
    pulse(DIV * 3); chk("R4", 0, 8'h03);
    wr(15, 8'h80); pulse(DIV); chk("R4", 0, 8'h04);
  endtask

  task automatic t_direct();
    wr(1, 8'h42); chk("R10", 1, 8'h42);
    pulse(DIV); chk("R10", 0, 8'h05); chk("R10", 1, 8'h42);
  endtask

  task automatic t_carry();
    set_all(8'h20, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
    pulse(DIV);
    chk("R5", 0, 8'h00); chk("R5", 1, 8'h00); chk("R5", 2, 8'h00);
    chk("R5", 3, 8'h01); chk("R5", 4, 8'h01); chk("R5", 5, 8'h01);
    chk("R5", 6, 8'h00); chk("R5", 7, 8'h21);
  endtask

  task automatic t_month();
    set_all(8'h20, 8'h23, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    pulse(DIV); chk("R6", 4, 8'h01); chk("R6", 5, 8'h05); chk("R6", 3, 8'h03);
    set_all(8'h20, 8'h23, 8'h01, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    pulse(DIV); chk("R6", 4, 8'h31); chk("R6", 5, 8'h01);
    set_all(8'h20, 8'h23, 8'h11, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    pulse(DIV); chk("R6", 4, 8'h01); chk("R6", 5, 8'h12);
  endtask

  task automatic feb(input logic [7:0] cen, yr, date, exp_date, exp_mon);
    set_all(cen, yr, 8'h02, date, 8'h01, 8'h23, 8'h59, 8'h59);
    pulse(DIV); chk("R7", 4, exp_date); chk("R7", 5, exp_mon);
  endtask

  task automatic t_leap();
    feb(8'h20, 8'h24, 8'h28, 8'h29, 8'h02);
    feb(8'h20, 8'h24, 8'h29, 8'h01, 8'h03);
    feb(8'h20, 8'h23, 8'h28, 8'h01, 8'h03);
    feb(8'h20, 8'h00, 8'h28, 8'h29, 8'h02);
    feb(8'h21, 8'h00, 8'h28, 8'h01, 8'h03);
    feb(8'h20, 8'h10, 8'h28, 8'h01, 8'h03);
  endtask

  task automatic t_freeze();
    set_all(8'h20, 8'h25, 8'h06, 8'h10, 8'h03, 8'h12, 8'h00, 8'h05);
    wr(15, 8'h00); chk("R8", 15, 8'h00);
    pulse(DIV * 2); chk("R8", 0, 8'h05);
    wr(15, 8'h80); chk("R8", 0, 8'h07);
  endtask

  task automatic t_stage();
    set_all(8'h20, 8'h25, 8'h06, 8'h10, 8'h03, 8'h00, 8'h00, 8'h58);
    wr(15, 8'h00);
    wr(1, 8'h10);
    pulse(DIV * 3);
    chk("R9", 1, 8'h10); chk("R9", 0, 8'h58);
    wr(15, 8'h80);
    chk("R9", 1, 8'h10); chk("R9", 0, 8'h01); chk("R9", 2, 8'h00);
  endtask

  task automatic t_bad_addr();
    wr(5'h08, 8'h55); wr(5'h0E, 8'h00); wr(5'h1F, 8'h00); wr(5'h10, 8'h00);
    chk("R11", 5'h08, 8'h00); chk("R11", 5'h1F, 8'h00);
    chk("R11", 15, 8'h80); chk("R11", 1, 8'h10); chk("R11", 0, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_read_gate();
    t_tick_rate();
    t_osc();
    t_direct();
    t_carry();
    t_month();
    t_leap();
    t_freeze();
    t_stage();
    t_bad_addr();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule